// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot (Dual Channel)

This block makes a clean output pulse of a programmed length from an asynchronous trigger. It counts clock cycles in place of an analog timing network. Each channel has two trigger lines. One starts a pulse on its rising edge, and the other starts a pulse on its falling edge. Each line counts only when its partner sits at the qualifying level. A trigger that arrives during a pulse restarts the full period. An active-low clear cuts a running pulse short and blocks all triggers while it is held low.

Two copies sit side by side. Each has its own triggers, clear, width and outputs. All asynchronous inputs pass through a two-stage synchronizer, and edges are found by comparing successive synchronized samples. The width is sampled at each valid trigger, so a later change does not affect a running pulse.

Top module: `pulse_pair_oneshot`

## Requirements
- R1: After reset every `pulse` bit is 0 and every `pulse_n` bit is 1, and `pulse_n` is always the complement of `pulse`.
- R2: A 0→1 change on `trig_rise[c]` starts a pulse only while `trig_fall[c]` is 1 and `clr_n[c]` is 1. With `trig_fall[c]` at 0 the edge does nothing.
- R3: A 1→0 change on `trig_fall[c]` starts a pulse only while `trig_rise[c]` is 0 and `clr_n[c]` is 1. With `trig_rise[c]` at 1 the edge does nothing.
- R4: A triggered pulse stays high for exactly the width in `width_cyc[16c+15:16c]`, counted in clock cycles. A width of 0 gives 1 cycle. The width is taken at the trigger, so changing it mid-pulse has no effect.
- R5: `pulse[c]` goes high on the third rising clock edge after the trigger input changes, for any programmed width.
- R6: A valid trigger during a pulse restarts the count. The pulse then ends exactly the programmed width after the last trigger.
- R7: Once `clr_n[c]` goes low, `pulse[c]` is forced low by the third rising clock edge, which can cut a pulse short.
- R8: Trigger edges are ignored while `clr_n[c]` is low. Triggers are accepted again once clear has been released and a 2-cycle recovery has passed.
- R9: The two channels are independent: activity on one channel never changes the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_rise | input | 2 | Per-channel trigger that fires on its rising edge |
| trig_fall | input | 2 | Per-channel trigger that fires on its falling edge |
| clr_n | input | 2 | Per-channel active-low clear |
| width_cyc | input | 32 | Per-channel pulse width in cycles, 16 bits per channel, channel 0 in the low half |
| pulse | output | 2 | Per-channel pulse output |
| pulse_n | output | 2 | Complement of `pulse` |

## Verification
A table of single triggers covers both edge types on both channels, with widths 0, 1, short and long. It separates a correct measured length from an off-by-one in the counter, and it confirms the fixed three-edge latency. Directed runs then cover the cases the table cannot reach:
- an edge whose partner line is at the wrong level, which must not fire;
- a retrigger, which must lengthen the pulse to one full width after the second edge;
- a width change mid-pulse, which must not affect the running pulse;
- a clear that cuts a pulse short and swallows a later edge;
- a clear on one channel while the other channel runs, which must not disturb the running channel.

// File: rtl/osh_pkg.sv
package osh_pkg;
  // order of the synchronized control bits inside one channel
  typedef struct packed {
    logic clr;
    logic fall;
    logic rise;
  } osh_pins_t;
  localparam int unsigned OSH_PIN_BITS = $bits(osh_pins_t);
endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
  parameter int unsigned BITS   = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  logic [STAGES-1:0][BITS-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/osh_chan.sv
module osh_chan
  import osh_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RECOVER = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  osh_pins_t        pins,
  input  logic [CNT_W-1:0] width,
  output logic             q,
  output logic             qn
);
  localparam int unsigned RW = (RECOVER > 1) ? $clog2(RECOVER) : 1;

  logic             rise_d, fall_d;
  logic             edge_rise, edge_fall, trig;
  logic             blk_q, blk_d;
  logic [RW-1:0]    rec_q, rec_d;
  logic             run_q, run_d, qn_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, blk_en;

  assign edge_rise = pins.rise & ~rise_d;
  assign edge_fall = ~pins.fall & fall_d;
  assign trig      = pins.clr & ~blk_q &
                     ((edge_rise & pins.fall) | (edge_fall & ~pins.rise));

  // clear latch with fixed recovery
  always_comb begin
    blk_d = blk_q;
    rec_d = rec_q;
    if (!pins.clr) begin
      blk_d = 1'b1;
      rec_d = RW'(RECOVER - 1);
    end else if (blk_q) begin
      if (rec_q == '0) blk_d = 1'b0;
      else             rec_d = rec_q - RW'(1);
    end
  end
  assign blk_en = ~pins.clr | blk_q;

  // pulse timer
  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!pins.clr) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (trig) begin
      run_d = 1'b1;
      cnt_d = (width == '0) ? '0 : width - CNT_W'(1);
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - CNT_W'(1);
    end
  end
  assign cnt_en = ~pins.clr | trig | run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_d <= 1'b0;
      fall_d <= 1'b0;
    end else begin
      rise_d <= pins.rise;
      fall_d <= pins.fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      rec_q <= '0;
    end else if (blk_en) begin
      blk_q <= blk_d;
      rec_q <= rec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      qn_q  <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_en) begin
      run_q <= run_d;
      qn_q  <= ~run_d;
      cnt_q <= cnt_d;
    end
  end

  assign q  = run_q;
  assign qn = qn_q;
endmodule

// File: rtl/pulse_pair_oneshot.sv
module pulse_pair_oneshot
  import osh_pkg::*;
#(
  parameter int unsigned CH          = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RECOVER     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH-1:0]       trig_rise,
  input  logic [CH-1:0]       trig_fall,
  input  logic [CH-1:0]       clr_n,
  input  logic [CH*CNT_W-1:0] width_cyc,
  output logic [CH-1:0]       pulse,
  output logic [CH-1:0]       pulse_n
);
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  for (genvar g = 0; g < int'(CH); g++) begin : g_ch
    osh_pins_t raw, syn;
    assign raw = '{clr: clr_n[g], fall: trig_fall[g], rise: trig_rise[g]};

    osh_sync #(.BITS(OSH_PIN_BITS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (core_rst_n),
      .d     (raw),
      .q     (syn)
    );

    osh_chan #(.CNT_W(CNT_W), .RECOVER(RECOVER)) u_chan (
      .clk   (clk),
      .rst_n (core_rst_n),
      .pins  (syn),
      .width (width_cyc[g*CNT_W +: CNT_W]),
      .q     (pulse[g]),
      .qn    (pulse_n[g])
    );
  end
endmodule

module pulse_pair_oneshot_chk #(
  parameter int unsigned CH    = 2,
  parameter int unsigned CNT_W = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CH-1:0] clr_n,
  input logic [CH-1:0] pulse,
  input logic [CH-1:0] pulse_n
);
  localparam logic [CNT_W+1:0] MAX_RUN = (CNT_W+2)'(1) << CNT_W;

  for (genvar g = 0; g < int'(CH); g++) begin : g_chk
    logic [CNT_W+1:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_len <= '0;
      else if (!pulse[g])  run_len <= '0;
      else if (run_len != '1) run_len <= run_len + 1'b1;
    end

    // R1
    out_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_n[g] == ~pulse[g]);
    // R7
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_n[g] && !$past(clr_n[g]) && !$past(clr_n[g], 2)) |=> !pulse[g]);
    // R8
    start_needs_clear_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse[g]) |-> $past(clr_n[g], 3));
    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= MAX_RUN);
  end
endmodule

bind pulse_pair_oneshot pulse_pair_oneshot_chk #(.CH(CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_n   (clr_n),
  .pulse   (pulse),
  .pulse_n (pulse_n)
);

// File: tb/pulse_pair_oneshot_test.sv
module pulse_pair_oneshot_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  trig_rise, trig_fall, clr_n;
  logic [31:0] width_cyc;
  logic [1:0]  pulse, pulse_n;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_pair_oneshot uut (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .trig_fall(trig_fall),
    .clr_n(clr_n), .width_cyc(width_cyc), .pulse(pulse), .pulse_n(pulse_n)
  );

  // {channel, kind (0 rise edge, 1 fall edge), width, expected length}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b0, 16'd5,  16'd5},
    {1'b0, 1'b1, 16'd1,  16'd1},
    {1'b0, 1'b0, 16'd0,  16'd1},
    {1'b1, 1'b1, 16'd12, 16'd12},
    {1'b1, 1'b0, 16'd3,  16'd3},
    {1'b0, 1'b1, 16'd40, 16'd40}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int ch, input int n);
    trig_rise[ch] = 1'b0;
    trig_fall[ch] = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic shot(input int ch, input bit kind, input int w, input int n,
                      output int hi, output int first);
    width_cyc[ch*16 +: 16] = 16'(w);
    if (kind) trig_fall[ch] = 1'b0;
    else      trig_rise[ch] = 1'b1;
    hi = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (pulse[ch]) begin
        hi++;
        if (first == 0) first = i;
      end
    end
    idle(ch, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    int hi, first, hi_a, hi_b;
    rst_n = 1'b0; trig_rise = 2'b00; trig_fall = 2'b11; clr_n = 2'b11;
    width_cyc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pulse == 2'b00, "R1 pulse in reset", pulse, 0);
    check(pulse_n == 2'b11, "R1 pulse_n in reset", pulse_n, 3);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(pulse == 2'b00 && pulse_n == 2'b11, "R1 idle after reset", {pulse, pulse_n}, 3);

    // table: R2 R3 R4 R5 R9
    for (int v = 0; v < 6; v++) begin
      shot(int'(VEC[v][33]), VEC[v][32], int'(VEC[v][31:16]),
           int'(VEC[v][31:16]) + 8, hi, first);
      check(first == 3, "R5 latency", first, 3);
      check(hi == int'(VEC[v][15:0]), VEC[v][32] ? "R3 R4 length" : "R2 R4 length",
            hi, int'(VEC[v][15:0]));
    end

    // R2 rise edge with fall line low is ignored
    width_cyc[15:0] = 16'd4;
    trig_fall[0] = 1'b0;
    repeat (12) @(negedge clk);
    trig_rise[0] = 1'b1; hi = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (pulse[0]) hi++; end
    check(hi == 0, "R2 unqualified rise", hi, 0);
    trig_fall[0] = 1'b1; repeat (12) @(negedge clk);
    idle(0, 4);

    // R3 fall edge with rise line high is ignored
    trig_rise[0] = 1'b1;
    repeat (12) @(negedge clk);
    trig_fall[0] = 1'b0; hi = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (pulse[0]) hi++; end
    check(hi == 0, "R3 unqualified fall", hi, 0);
    idle(0, 4);

    // R6 retrigger: first edge, second edge 4 cycles later, width 10
    width_cyc[15:0] = 16'd10;
    trig_rise[0] = 1'b1; hi = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (pulse[0]) hi++;
      if (i == 2) trig_rise[0] = 1'b0;
      if (i == 4) trig_rise[0] = 1'b1;
    end
    check(hi == 14, "R6 retrigger length", hi, 14);
    idle(0, 4);

    // R4 width change mid-pulse has no effect
    width_cyc[31:16] = 16'd10;
    trig_rise[1] = 1'b1; hi = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (pulse[1]) hi++;
      if (i == 4) width_cyc[31:16] = 16'd3;
    end
    check(hi == 10, "R4 width held", hi, 10);
    idle(1, 4);

    // R7 clear truncates, R8 edges during clear ignored
    width_cyc[15:0] = 16'd20;
    trig_rise[0] = 1'b1; hi_a = 0; hi_b = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (pulse[0]) begin if (i < 9) hi_a++; else hi_b++; end
      if (i == 6)  clr_n[0] = 1'b0;
      if (i == 10) trig_rise[0] = 1'b0;
      if (i == 12) trig_rise[0] = 1'b1;
    end
    check(hi_a == 6, "R7 truncated length", hi_a, 6);
    check(hi_b == 0, "R8 edge during clear", hi_b, 0);
    clr_n[0] = 1'b1;
    repeat (4) @(negedge clk);
    check(pulse[0] == 1'b0, "R8 no start on release", pulse[0], 0);
    idle(0, 6);
    shot(0, 1'b0, 7, 15, hi, first);
    check(hi == 7 && first == 3, "R8 accepted after recovery", hi, 7);

    // R9 clear and edge on channel 1 while channel 0 runs
    width_cyc[15:0] = 16'd15;
    trig_rise[0] = 1'b1; clr_n[1] = 1'b0; trig_fall[1] = 1'b0;
    hi_a = 0; hi_b = 0;
    for (int i = 1; i <= 25; i++) begin
      @(negedge clk);
      if (pulse[0]) hi_a++;
      if (pulse[1]) hi_b++;
      if (pulse_n != ~pulse) err_cnt++;
    end
    check(hi_a == 15, "R9 channel 0 unaffected", hi_a, 15);
    check(hi_b == 0, "R9 channel 1 held clear", hi_b, 0);
    clr_n[1] = 1'b1;
    idle(0, 2); idle(1, 8);
    check(pulse_n == ~pulse, "R1 complement at end", pulse_n, ~pulse);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule